// File: doc/BRIEF.md
# Preloadable 8-bit Timer / Event Counter

This block is an 8-bit up-counter with a reload value, steered by one control byte. It runs in one of three modes. As an interval timer it counts a divided internal time base. As an event counter it counts chosen transitions on an external pin. As a pulse-width meter it counts the divided time base only while the pin sits at its active level. When the count steps past all ones, the counter takes the reload value and sends a one-cycle interrupt request.

Software reaches the block through a small register port with three addresses: control, reload and count. All logic runs on a single system clock. The two internal time bases enter as single-cycle enable pulses, `clk_en_a` and `clk_en_b`. The control byte picks one of them, and a free-running divider scales it down. The external pin passes through a two-flop synchronizer before its edges are detected.

A write to the reload register while the run bit is low goes into the count at once. A write while the run bit is high only changes the reload value, which the count takes at its next wrap. The register port is a plain write strobe with a combinational read. It never stalls, so no back-pressure applies.

Top module: `tmr8_event_unit`

## Requirements
- R1: After reset the control, reload and count registers all read 0 and `irq_o` is low.
- R2: The register addresses are 0 for control, 1 for reload and 2 for count. Count is read-only. The control fields are: bits 7:6 mode (00 idle, 01 event count, 10 interval timer, 11 pulse-width capture), bit 5 source (0 = `clk_en_a`, 1 = `clk_en_b`), bit 4 run, bit 3 polarity (0 = rising edge / high active level, 1 = falling edge / low active level), and bits 2:0 the divider exponent N.
- R3: In timer mode the count rises by exactly one for every 2^N pulses of the selected source.
- R4: Pulses on the source that is not selected have no effect on the count.
- R5: The count holds its value while the run bit is low, and also while the mode is idle.
- R6: In event mode each selected pin edge adds exactly one to the count. The divider exponent has no effect in this mode.
- R7: An increment from all ones loads the reload value into the count. `irq_o` is then high for exactly the one following cycle.
- R8: A reload write while the run bit is low appears in the count on the next cycle.
- R9: A reload write while the run bit is high leaves the count stepping normally, and the count takes the new value at the next wrap. If the write lands in the same cycle as the wrap, the new value is the one loaded.
- R10: In capture mode the count advances on divided ticks only while the synchronized pin is at its active level. When the pin leaves that level, the run bit clears by itself, and later active periods are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| clk_en_a | input | 1 | Internal time base A, enable pulses |
| clk_en_b | input | 1 | Internal time base B, enable pulses |
| ext_pin | input | 1 | External event / gate pin (asynchronous) |
| irq_o | output | 1 | One-cycle interrupt request on wrap |

## Verification
A reload write and a counter wrap can fall in the same cycle. The bench provokes this by loading FE while stopped, starting the timer with the divider at one, and timing the reload write so that it is captured on the edge where the count steps out of FF. The test passes only if that edge loads the freshly written value and raises the interrupt. In capture mode, the automatic clearing of the run bit is judged by reading the control byte back and by confirming that a later active pulse leaves the count unchanged.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_CAPT  = 2'b11
  } tmr_mode_e;

  // Control byte, MSB first
  typedef struct packed {
    tmr_mode_e  mode;      // 7:6
    logic       src_b;     // 5
    logic       run;       // 4
    logic       pol_low;   // 3
    logic [2:0] psc;       // 2:0
  } tmr_ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PRE  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (src_en) div_q <= div_q + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(sel));
  end

  // tick on the falling edge of divider bit sel-1 (all low bits wrap)
  assign tick = src_en && ((div_q & mask) == mask);

endmodule

// File: rtl/tmr8_pin_sync.sv
module tmr8_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o && !prev_q;
  assign fall_o  = !level_o && prev_q;

endmodule

// File: rtl/tmr8_count_core.sv
module tmr8_count_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         inc,
  input  logic         pre_wr,
  input  logic [W-1:0] pre_data,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] pre_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, pre_q, reload_val;

  assign wrap_o     = inc && (cnt_q == '1);
  assign reload_val = pre_wr ? pre_data : pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_wr) pre_q <= pre_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (pre_wr && !run)  cnt_q <= pre_data;
    else if (wrap_o)          cnt_q <= reload_val;
    else if (inc)             cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign pre_o = pre_q;

endmodule

// File: rtl/tmr8_event_unit.sv
module tmr8_event_unit
  import tmr8_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PSC_W    = 3,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             clk_en_a,
  input  logic             clk_en_b,
  input  logic             ext_pin,
  output logic             irq_o
);
  tmr_ctrl_t        ctrl_q;
  logic             src_en, tick;
  logic             pin_lvl, pin_rise, pin_fall;
  logic             active_lvl, evt_edge, capt_end;
  logic             inc, wrap, irq_q;
  logic             ctrl_wr, pre_wr;
  logic [CNT_W-1:0] cnt_w, pre_w;
  logic             run_w;
  logic [1:0]       mode_w;

  assign ctrl_wr = reg_wr_en && (reg_addr == ADDR_CTRL);
  assign pre_wr  = reg_wr_en && (reg_addr == ADDR_PRE);
  assign run_w   = ctrl_q.run;
  assign mode_w  = ctrl_q.mode;

  assign src_en  = ctrl_q.src_b ? clk_en_b : clk_en_a;

  tmr8_prescaler #(.SEL_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .sel(ctrl_q.psc), .tick(tick)
  );

  tmr8_pin_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin),
    .level_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  assign active_lvl = pin_lvl ^ ctrl_q.pol_low;
  assign evt_edge   = ctrl_q.pol_low ? pin_fall : pin_rise;
  assign capt_end   = ctrl_q.pol_low ? pin_rise : pin_fall;

  always_comb begin
    inc = 1'b0;
    if (ctrl_q.run) begin
      case (ctrl_q.mode)
        MODE_EVENT: inc = evt_edge;
        MODE_TIMER: inc = tick;
        MODE_CAPT:  inc = tick && active_lvl;
        default:    inc = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (ctrl_wr)
      ctrl_q <= tmr_ctrl_t'(reg_wdata[7:0]);
    else if (ctrl_q.run && ctrl_q.mode == MODE_CAPT && capt_end)
      ctrl_q.run <= 1'b0;
  end

  tmr8_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .inc(inc),
    .pre_wr(pre_wr), .pre_data(reg_wdata),
    .cnt_o(cnt_w), .pre_o(pre_w), .wrap_o(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= wrap;
  end
  assign irq_o = irq_q;

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = CNT_W'(ctrl_q);
      ADDR_PRE:  reg_rdata = pre_w;
      ADDR_CNT:  reg_rdata = cnt_w;
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/tmr8_event_chk.sv
module tmr8_event_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic             irq_o,
  input logic             run_w,
  input logic [1:0]       mode_w,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] pre_w
);
  // R7: interrupt lasts a single cycle
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R7: while the interrupt is up, the count holds the reload value
  a_r7_irq_reload: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cnt_w == pre_w));

  // R5: run low and no write: count does not move
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run_w) && !$past(reg_wr_en)) |-> $stable(cnt_w));

  // R3: without a write the count only steps by one or reloads on wrap
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_wr_en) && !$stable(cnt_w)) |->
      ((cnt_w == CNT_W'($past(cnt_w) + 1'b1)) || irq_o));

  // R10: run clears by itself only in capture mode
  a_r10_autoclr: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run_w) && !$past(reg_wr_en)) |-> ($past(mode_w) == 2'b11));

endmodule

bind tmr8_event_unit tmr8_event_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .irq_o(irq_o),
  .run_w(run_w), .mode_w(mode_w), .cnt_w(cnt_w), .pre_w(pre_w)
);

// File: tb/sim_tmr8_event_unit.sv
module sim_tmr8_event_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       clk_en_a = 1'b1;
  logic       clk_en_b = 1'b0;
  logic       ext_pin = 1'b0;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tmr8_event_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en_a(clk_en_a),
    .clk_en_b(clk_en_b), .ext_pin(ext_pin), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_count();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 reload", v, 8'h00);
    rd(2'd2, v); chk("R1 count", v, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_timer_wrap();
    logic [7:0] v;
    int irqs = 0;
    wr(2'd1, 8'hF0);
    rd(2'd2, v); chk("R8 immediate reload", v, 8'hF0);
    wr(2'd0, 8'h90);
    for (int i = 1; i <= 17; i++) begin
      @(negedge clk);
      rd(2'd2, v);
      if (irq_o) irqs++;
      if (i == 8)  chk("R3 step count", v, 8'hF8);
      if (i == 16) begin
        chk("R7 reload on wrap", v, 8'hF0);
        chk("R7 irq on wrap", {7'd0, irq_o}, 8'h01);
      end
    end
    chk("R7 single irq pulse", 8'(irqs), 8'd1);
    // R9: reload write while running is deferred
    wr(2'd1, 8'h20);
    rd(2'd2, v); chk("R9 count not replaced", v, 8'hF3);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq_o) begin
        rd(2'd2, v); chk("R9 deferred reload", v, 8'h20);
        break;
      end
    end
  endtask

  task automatic t_collision();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h90);
    wr(2'd1, 8'h77);   // captured on the edge that wraps FF
    rd(2'd2, v);
    chk("R9 same-cycle reload", v, 8'h77);
    chk("R9 same-cycle irq", {7'd0, irq_o}, 8'h01);
  endtask

  task automatic t_hold();
    logic [7:0] a, b;
    wr(2'd0, 8'h80);
    rd(2'd2, a); idle(10); rd(2'd2, b);
    chk("R5 run low holds", b, a);
    wr(2'd0, 8'h10);
    rd(2'd2, a); idle(10); rd(2'd2, b);
    chk("R5 idle mode holds", b, a);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = 1'b1; idle(3);
      ext_pin = 1'b0; idle(3);
    end
  endtask

  task automatic t_event();
    logic [7:0] v;
    clear_count();
    wr(2'd0, 8'h50);
    pulses(4); idle(5);
    rd(2'd2, v); chk("R6 rising edges", v, 8'h04);
    wr(2'd0, 8'h5F);
    pulses(3); idle(5);
    rd(2'd2, v); chk("R6 falling edges, divider ignored", v, 8'h07);
  endtask

  task automatic t_source();
    logic [7:0] v;
    clear_count();
    wr(2'd0, 8'h92);
    idle(14);
    wr(2'd0, 8'h80);
    rd(2'd2, v); chk("R3 divide by 4 over 16 pulses", v, 8'h04);
    clear_count();
    wr(2'd0, 8'hB2);
    for (int i = 0; i < 8; i++) begin
      clk_en_b = 1'b1; idle(1);
      clk_en_b = 1'b0; idle(1);
    end
    idle(3);
    rd(2'd2, v); chk("R4 source B divided", v, 8'h02);
    idle(10);
    rd(2'd2, v); chk("R4 source A ignored", v, 8'h02);
  endtask

  task automatic t_capture();
    logic [7:0] v;
    clear_count();
    wr(2'd0, 8'hD0);
    idle(5);
    rd(2'd2, v); chk("R10 no count while inactive", v, 8'h00);
    ext_pin = 1'b1; idle(10);
    ext_pin = 1'b0; idle(6);
    rd(2'd2, v); chk("R10 active width", v, 8'h0A);
    rd(2'd0, v); chk("R10 run auto-cleared", v, 8'hC0);
    ext_pin = 1'b1; idle(6);
    ext_pin = 1'b0; idle(4);
    rd(2'd2, v); chk("R10 later pulse ignored", v, 8'h0A);
  endtask

  task automatic t_ctrl_readback();
    logic [7:0] v;
    wr(2'd0, 8'h2B);
    rd(2'd0, v); chk("R2 control readback", v, 8'h2B);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_timer_wrap();
    t_collision();
    t_hold();
    t_event();
    t_source();
    t_capture();
    t_ctrl_readback();
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule